// File: doc/BRIEF.md
# SPI Serial EEPROM Transfer Engine

This block is a host-side master that moves byte streams to and from a small serial EEPROM over a four-wire SPI link. A request gives a start address, a byte count and a direction. The engine checks the request against the device size and then builds the command frames itself. On a read it sends one read command followed by the address, and then streams back as many bytes as were asked for. A write is cut into pieces that never straddle a write-block boundary. Each piece is preceded by its own write-enable frame. After each piece the engine polls the status register until the device leaves its busy state.

Two configuration inputs select how the address is sent. It can go as two bytes, high byte first. It can go as one byte. It can also go as one byte with address bit 8 folded into the command byte. Write data enters through a valid/ready byte port, and read data leaves as a one-cycle valid strobe. The serial clock runs in mode 0. Its half period is set by a parameter, counted in system clock cycles.

Top module: `eeprom_xfer_engine`

## Requirements
- R1: Every write piece is sent as two separate chip-select frames. The first holds only the write-enable opcode 0x06. The second holds the write opcode 0x02, then the address, then the data. The read opcode is 0x03 and the status-read opcode is 0x05.
- R2: With `cfg_two_addr`=1 and `cfg_munge`=0, two address bytes follow the opcode, bits 15:8 first and then bits 7:0. With `cfg_two_addr`=0 and `cfg_munge`=0, only bits 7:0 are sent.
- R3: With `cfg_munge`=1, bit 3 of the read or write opcode carries address bit 8, so a write to 0x1xx uses 0x0A and a read uses 0x0B. Only address bits 7:0 follow the opcode.
- R4: The data bytes of one write frame all lie in the same BLOCK_SIZE-aligned block. A longer write is split at block boundaries into consecutive frames.
- R5: After each write frame the engine sends status-read frames of opcode 0x05 plus one received byte. It keeps doing so while bit 0 of that byte (busy) is 1. It starts the next piece, or finishes, after the first poll that returns bit 0 = 0.
- R6: If POLL_LIMIT status reads in a row all report busy, the engine stops, raises `err_timeout` and pulses `done`, and sends no further frames. Both error flags are cleared by the next `start`.
- R7: A read is one chip-select frame. The engine presents each received byte on `rd_data` with a one-cycle `rd_valid`, in ascending address order, with no block-size limit.
- R8: A request with `start_addr + length > DEV_SIZE` raises `err_range`, pulses `done` and sends no frame. A request with `length` = 0 pulses `done` with no error and no frame. A request that ends exactly at DEV_SIZE is accepted.
- R9: The SPI runs in mode 0, most significant bit first. `sck` idles low and is high only while `cs_n` is low, and each high phase lasts HALF_DIV clock cycles.
- R10: After reset, `cs_n` is 1, `sck` is 0 and `busy` is 0.
- R11: `wr_ready` is asserted only during the data phase of a write. Exactly one byte is taken per handshake, in address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken while idle |
| op_write | input | 1 | 1 = write request, 0 = read request |
| start_addr | input | ADDR_W | First byte address |
| length | input | ADDR_W+1 | Byte count |
| cfg_two_addr | input | 1 | Send two address bytes |
| cfg_munge | input | 1 | Fold address bit 8 into opcode bit 3 |
| wr_data | input | 8 | Write data byte |
| wr_valid | input | 1 | Write data byte present |
| wr_ready | output | 1 | Engine takes the write byte |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read byte strobe |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err_range | output | 1 | Last request was out of range |
| err_timeout | output | 1 | Last write hit the poll limit |
| sck | output | 1 | SPI serial clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to the device |
| miso | input | 1 | SPI data from the device |

## Verification
The bench drives a behavioural EEPROM that decodes each frame. The model counts write-enable, write, read and status frames, flags a write made without the latch set, and flags any data byte that leaves the block in which its frame started. A 20-byte write starting two bytes before a block edge must come out as exactly three pieces. An engine that ignored the alignment would show a block violation or the wrong frame count. An engine that skipped the latch would show a latch violation. Read-back runs in all three address modes, including a folded-bit read that crosses from 0xFF to 0x100 and a read that ends exactly at the device size. Wrong address framing shows up as scoreboard mismatches or as unexpected opcodes. A device held permanently busy must produce exactly POLL_LIMIT status frames and then the timeout flag. A requests past the end of the device and a zero-length request must not produce a single chip-select frame.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    localparam logic [7:0] OPC_WRSR  = 8'h01;
    localparam logic [7:0] OPC_WRITE = 8'h02;
    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_WRDI  = 8'h04;
    localparam logic [7:0] OPC_RDSR  = 8'h05;
    localparam logic [7:0] OPC_WREN  = 8'h06;

    // status byte fields used by the engine
    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_WEL_BIT  = 1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WREN,
        ST_WREN_GAP,
        ST_OPC,
        ST_AHI,
        ST_ALO,
        ST_WDATA,
        ST_RDATA,
        ST_XFER_GAP,
        ST_POLL_OPC,
        ST_POLL_RD,
        ST_POLL_GAP
    } xfer_state_e;

    // command byte, optionally carrying address bit 8 in bit 3
    function automatic logic [7:0] cmd_byte(input logic [7:0] base,
                                            input logic       a8,
                                            input logic       fold);
        cmd_byte = base | ((fold & a8) ? 8'h08 : 8'h00);
    endfunction

    // chip select is active in every state that moves a byte
    function automatic logic frame_state(input xfer_state_e s);
        case (s)
            ST_WREN, ST_OPC, ST_AHI, ST_ALO, ST_WDATA,
            ST_RDATA, ST_POLL_OPC, ST_POLL_RD: frame_state = 1'b1;
            default:                           frame_state = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/eeprom_spi_shifter.sv
module eeprom_spi_shifter #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       byte_done
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    logic             active;
    logic             sck_q;
    logic [DIV_W-1:0] div_cnt;
    logic [2:0]       bit_idx;
    logic [7:0]       sh;
    logic [7:0]       rx;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            sck_q   <= 1'b0;
            div_cnt <= '0;
            bit_idx <= '0;
            sh      <= '0;
            rx      <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active) begin
                if (go) begin
                    active  <= 1'b1;
                    sh      <= tx_byte;
                    div_cnt <= '0;
                    bit_idx <= '0;
                    sck_q   <= 1'b0;
                end
            end else if (div_cnt == DIV_LAST) begin
                div_cnt <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;               // rising edge: sample
                    rx    <= {rx[6:0], miso};
                end else begin
                    sck_q <= 1'b0;               // falling edge: shift
                    sh    <= {sh[6:0], 1'b0};
                    if (bit_idx == 3'd7) begin
                        active <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 3'd1;
                    end
                end
            end else begin
                div_cnt <= div_cnt + DIV_W'(1);
            end
        end
    end

    assign sck       = sck_q;
    assign mosi      = sh[7];
    assign rx_byte   = rx;
    assign byte_done = done_q;

    p_sck_idle_low_r9: assert property (@(posedge clk) disable iff (rst)
        !active |-> !sck_q);

    p_done_after_fall_r9: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!sck_q && !active));

endmodule

// File: rtl/eeprom_chunker.sv
module eeprom_chunker #(
    parameter int ADDR_W     = 9,
    parameter int LEN_W      = 10,
    parameter int BLOCK_SIZE = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  remain,
    output logic [LEN_W-1:0]  chunk_len
);
    localparam int BLK_W = $clog2(BLOCK_SIZE);

    logic [LEN_W-1:0] room;

    always_comb begin
        room      = LEN_W'(BLOCK_SIZE) - LEN_W'(addr[BLK_W-1:0]);
        chunk_len = (remain < room) ? remain : room;
    end

endmodule

// File: rtl/eeprom_poll_counter.sv
module eeprom_poll_counter #(
    parameter int POLL_LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic expired
);
    localparam int CNT_W = $clog2(POLL_LIMIT + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + CNT_W'(1);
    end

    assign expired = (cnt >= CNT_W'(POLL_LIMIT));

    p_poll_below_limit_r6: assert property (@(posedge clk) disable iff (rst)
        inc |-> (cnt < CNT_W'(POLL_LIMIT)));

endmodule

// File: rtl/eeprom_xfer_engine.sv
module eeprom_xfer_engine
    import eeprom_pkg::*;
#(
    parameter int DEV_SIZE   = 512,
    parameter int BLOCK_SIZE = 16,
    parameter int HALF_DIV   = 2,
    parameter int POLL_LIMIT = 8,
    localparam int ADDR_W    = $clog2(DEV_SIZE),
    localparam int LEN_W     = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              op_write,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  length,
    input  logic              cfg_two_addr,
    input  logic              cfg_munge,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              busy,
    output logic              done,
    output logic              err_range,
    output logic              err_timeout,
    output logic              sck,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    localparam int BLK_W = $clog2(BLOCK_SIZE);
    localparam int HI_W  = ADDR_W - BLK_W;

    xfer_state_e       state;
    logic              issued;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  remain;
    logic [LEN_W-1:0]  chunk_left;
    logic [HI_W-1:0]   chunk_blk;
    logic              is_write;
    logic [7:0]        status_q;
    logic              cs_n_q;
    logic              done_q, rd_valid_q, err_range_q, err_to_q;
    logic [7:0]        rd_data_q;

    logic              go, step, sh_done;
    logic [7:0]        tx_byte, sh_rx;
    logic [15:0]       addr16;
    logic [LEN_W-1:0]  chunk_len;
    logic              poll_clr, poll_inc, poll_expired;
    logic              range_bad;
    logic [LEN_W:0]    req_end;

    eeprom_spi_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk(clk), .rst(rst), .go(go), .tx_byte(tx_byte), .miso(miso),
        .sck(sck), .mosi(mosi), .rx_byte(sh_rx), .byte_done(sh_done)
    );

    eeprom_chunker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BLOCK_SIZE(BLOCK_SIZE)) u_chunk (
        .addr(cur_addr), .remain(remain), .chunk_len(chunk_len)
    );

    eeprom_poll_counter #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
        .clk(clk), .rst(rst), .clr(poll_clr), .inc(poll_inc), .expired(poll_expired)
    );

    always_comb begin
        addr16    = 16'(cur_addr);
        req_end   = (LEN_W+1)'(start_addr) + (LEN_W+1)'(length);
        range_bad = (req_end > (LEN_W+1)'(DEV_SIZE));
        step      = issued && sh_done;
        wr_ready  = (state == ST_WDATA) && !issued;
        go        = frame_state(state) && !issued &&
                    ((state != ST_WDATA) || wr_valid);
        poll_clr  = (state == ST_XFER_GAP);
        poll_inc  = (state == ST_POLL_RD) && step;
        case (state)
            ST_WREN:     tx_byte = OPC_WREN;
            ST_OPC:      tx_byte = cmd_byte(is_write ? OPC_WRITE : OPC_READ,
                                            addr16[8], cfg_munge);
            ST_AHI:      tx_byte = addr16[15:8];
            ST_ALO:      tx_byte = addr16[7:0];
            ST_WDATA:    tx_byte = wr_data;
            ST_POLL_OPC: tx_byte = OPC_RDSR;
            default:     tx_byte = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            issued      <= 1'b0;
            cur_addr    <= '0;
            remain      <= '0;
            chunk_left  <= '0;
            chunk_blk   <= '0;
            is_write    <= 1'b0;
            status_q    <= '0;
            done_q      <= 1'b0;
            rd_valid_q  <= 1'b0;
            rd_data_q   <= '0;
            err_range_q <= 1'b0;
            err_to_q    <= 1'b0;
        end else begin
            done_q     <= 1'b0;
            rd_valid_q <= 1'b0;
            if (go)   issued <= 1'b1;
            if (step) issued <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    err_range_q <= 1'b0;
                    err_to_q    <= 1'b0;
                    if (range_bad) begin
                        err_range_q <= 1'b1;
                        done_q      <= 1'b1;
                    end else if (length == '0) begin
                        done_q <= 1'b1;
                    end else begin
                        cur_addr   <= start_addr;
                        remain     <= length;
                        chunk_left <= length;
                        is_write   <= op_write;
                        state      <= op_write ? ST_WREN : ST_OPC;
                    end
                end
                ST_WREN: if (step) state <= ST_WREN_GAP;
                ST_WREN_GAP: begin
                    chunk_left <= chunk_len;
                    chunk_blk  <= cur_addr[ADDR_W-1:BLK_W];
                    state      <= ST_OPC;
                end
                ST_OPC: if (step)
                    state <= (cfg_two_addr && !cfg_munge) ? ST_AHI : ST_ALO;
                ST_AHI: if (step) state <= ST_ALO;
                ST_ALO: if (step) state <= is_write ? ST_WDATA : ST_RDATA;
                ST_WDATA, ST_RDATA: if (step) begin
                    if (state == ST_RDATA) begin
                        rd_valid_q <= 1'b1;
                        rd_data_q  <= sh_rx;
                    end
                    cur_addr   <= cur_addr + ADDR_W'(1);
                    remain     <= remain - LEN_W'(1);
                    chunk_left <= chunk_left - LEN_W'(1);
                    if (chunk_left == LEN_W'(1)) state <= ST_XFER_GAP;
                end
                ST_XFER_GAP: begin
                    if (is_write) begin
                        state <= ST_POLL_OPC;
                    end else begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                ST_POLL_OPC: if (step) state <= ST_POLL_RD;
                ST_POLL_RD: if (step) begin
                    status_q <= sh_rx;
                    state    <= ST_POLL_GAP;
                end
                ST_POLL_GAP: begin
                    if (!status_q[STAT_BUSY_BIT]) begin
                        if (remain != '0) begin
                            state <= ST_WREN;
                        end else begin
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end
                    end else if (poll_expired) begin
                        err_to_q <= 1'b1;
                        done_q   <= 1'b1;
                        state    <= ST_IDLE;
                    end else begin
                        state <= ST_POLL_OPC;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cs_n_q <= 1'b1;
        else     cs_n_q <= !frame_state(state);
    end

    assign cs_n        = cs_n_q;
    assign busy        = (state != ST_IDLE);
    assign done        = done_q;
    assign rd_valid    = rd_valid_q;
    assign rd_data     = rd_data_q;
    assign err_range   = err_range_q;
    assign err_timeout = err_to_q;

    p_sck_needs_cs_r9: assert property (@(posedge clk) disable iff (rst)
        sck |-> !cs_n);

    p_chunk_one_block_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WDATA && go) |-> (cur_addr[ADDR_W-1:BLK_W] == chunk_blk));

    p_range_reject_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start && range_bad) |=> (err_range && done && !busy));

    p_wready_write_op_r11: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> is_write);

    p_timeout_abort_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_POLL_GAP && status_q[STAT_BUSY_BIT] && poll_expired)
        |=> (err_timeout && !busy));

    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: tb/eeprom_xfer_engine_tb.sv
module eeprom_xfer_engine_tb;
    localparam int DEV_SIZE = 512, BLOCK = 16, HALF_DIV = 2, POLL_LIMIT = 8;
    localparam int BUSY_POLLS = 3;
    localparam int AW = $clog2(DEV_SIZE), LW = AW + 1;

    logic clk = 1'b0, rst = 1'b1;
    logic start = 1'b0, op_write = 1'b0, cfg_two = 1'b1, cfg_munge = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [LW-1:0] length = '0;
    logic [7:0] wr_data = '0;
    logic wr_valid = 1'b0, wr_ready;
    logic [7:0] rd_data;
    logic rd_valid, busy, done, err_range, err_timeout, sck, cs_n, mosi;
    logic miso = 1'b0;

    always #5 clk = ~clk;

    eeprom_xfer_engine #(.DEV_SIZE(DEV_SIZE), .BLOCK_SIZE(BLOCK),
                         .HALF_DIV(HALF_DIV), .POLL_LIMIT(POLL_LIMIT)) u_dut (
        .clk(clk), .rst(rst), .start(start), .op_write(op_write),
        .start_addr(start_addr), .length(length), .cfg_two_addr(cfg_two),
        .cfg_munge(cfg_munge), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .busy(busy), .done(done), .err_range(err_range),
        .err_timeout(err_timeout), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .miso(miso)
    );

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- EEPROM model ----------------
    logic [7:0] mem [0:DEV_SIZE-1];
    logic [7:0] ref_mem [0:DEV_SIZE-1];
    logic wel = 1'b0, stuck = 1'b0;
    int busy_cnt = 0;
    int n_frames = 0, n_wren = 0, n_write = 0, n_read = 0, n_rdsr = 0;
    int n_bad_op = 0, n_wel_viol = 0, n_blk_viol = 0;
    int idx = 0, bc = 0, kind = 0, need = 0, got = 0, ndata = 0, blk0 = 0;
    logic [15:0] maddr = '0;
    logic [7:0] rxs = '0, txs = '0, nxt = '0;

    task automatic handle(input logic [7:0] b);
        logic [7:0] base;
        logic a8;
        if (idx == 0) begin
            base = b; a8 = 1'b0; nxt = 8'h00; kind = 0;
            if (cfg_munge && (b == 8'h0A || b == 8'h0B)) begin
                base = b & 8'hF7; a8 = 1'b1;
            end
            case (base)
                8'h06: begin wel = 1'b1; n_wren++; end
                8'h02: begin kind = 1; n_write++; if (!wel) n_wel_viol++; end
                8'h03: begin kind = 2; n_read++; end
                8'h05: begin kind = 3; n_rdsr++;
                             nxt = {6'b0, wel, (stuck || busy_cnt > 0)}; end
                default: n_bad_op++;
            endcase
            maddr = {7'b0, a8, 8'h00};
            need  = (cfg_two && !cfg_munge) ? 2 : 1;
            got   = 0; ndata = 0;
        end else if ((kind == 1 || kind == 2) && got < need) begin
            if (need == 2 && got == 0) maddr = {b, 8'h00};
            else                       maddr = maddr | {8'h00, b};
            got++;
            if (got == need && kind == 2) begin
                nxt = mem[maddr[AW-1:0]]; maddr++;
            end
        end else if (kind == 1) begin
            if (ndata == 0) blk0 = int'(maddr) / BLOCK;
            else if (int'(maddr) / BLOCK != blk0) n_blk_viol++;
            mem[maddr[AW-1:0]] = b; maddr++; ndata++;
        end else if (kind == 2) begin
            nxt = mem[maddr[AW-1:0]]; maddr++;
        end else begin
            nxt = 8'h00;
        end
        idx++;
    endtask

    always @(negedge cs_n) begin
        n_frames++; idx = 0; bc = 0; nxt = 8'h00; txs = 8'h00; miso = 1'b0;
    end

    always @(posedge cs_n) begin
        if (kind == 1 && ndata > 0) begin busy_cnt = BUSY_POLLS; wel = 1'b0; end
        if (kind == 3 && busy_cnt > 0) busy_cnt--;
        kind = 0;
    end

    always @(posedge sck) if (!cs_n) begin
        rxs = {rxs[6:0], mosi}; bc++;
        if (bc == 8) begin bc = 0; handle(rxs); end
    end

    always @(negedge sck) if (!cs_n) begin
        if (bc == 0) txs = nxt;
        miso = txs[7]; txs = {txs[6:0], 1'b0};
    end

    // ---------------- SPI line monitor (R9) ----------------
    int hi_run = 0, half_viol = 0, sck_no_cs = 0, wready_rd = 0;
    bit rd_op = 1'b0;
    always @(negedge clk) begin
        if (sck && cs_n) sck_no_cs++;
        if (sck) hi_run++;
        else if (hi_run > 0) begin
            if (hi_run != HALF_DIV) half_viol++;
            hi_run = 0;
        end
        if (rd_op && wr_ready) wready_rd++;
    end

    // ---------------- write driver ----------------
    logic [7:0] wdq[$];
    bit take = 1'b0;
    always @(negedge clk) begin
        if (take) void'(wdq.pop_front());
        wr_valid = (wdq.size() > 0);
        wr_data  = wr_valid ? wdq[0] : 8'h00;
        take     = wr_valid && wr_ready;
    end

    // ---------------- read scoreboard ----------------
    logic [7:0] expq[$];
    string cur_req = "R7";
    always @(negedge clk) if (rd_valid) begin
        if (expq.size() == 0) chk(1'b0, cur_req, "unexpected read byte", int'(rd_data), -1);
        else begin
            logic [7:0] e;
            e = expq.pop_front();
            chk(rd_data == e, cur_req, "read byte", int'(rd_data), int'(e));
        end
    end

    // ---------------- watchdog ----------------
    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    bit got_done;
    task automatic run_op(input bit wr, input int addr, input int len,
                          input bit two, input bit mg);
        @(negedge clk);
        cfg_two = two; cfg_munge = mg; op_write = wr;
        start_addr = AW'(addr); length = LW'(len); start = 1'b1; rd_op = !wr;
        @(negedge clk);
        start = 1'b0; got_done = 1'b0;
        for (int i = 0; i < 40000; i++) begin
            if (done) begin got_done = 1'b1; break; end
            @(negedge clk);
        end
        rd_op = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_write(input int addr, input int len, input int seed,
                            input bit two, input bit mg);
        for (int i = 0; i < len; i++) begin
            logic [7:0] v;
            v = 8'((seed + i * 37) & 8'hFF);
            wdq.push_back(v);
            ref_mem[(addr + i) % DEV_SIZE] = v;
        end
        run_op(1'b1, addr, len, two, mg);
    endtask

    task automatic do_read(input int addr, input int len, input bit two,
                           input bit mg, input string req);
        cur_req = req;
        for (int i = 0; i < len; i++) expq.push_back(ref_mem[addr + i]);
        run_op(1'b0, addr, len, two, mg);
        chk(expq.size() == 0, req, "read bytes outstanding", expq.size(), 0);
        expq.delete();
    endtask

    int f0, w0, e0, s0, r0;
    task automatic snap();
        f0 = n_frames; w0 = n_write; e0 = n_wren; s0 = n_rdsr; r0 = n_read;
    endtask

    initial begin
        for (int i = 0; i < DEV_SIZE; i++) begin
            mem[i] = 8'(i ^ 8'h5A); ref_mem[i] = 8'(i ^ 8'h5A);
        end
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R10", "cs_n in reset", int'(cs_n), 1);
        chk(sck == 1'b0, "R10", "sck in reset", int'(sck), 0);
        chk(busy == 1'b0, "R10", "busy in reset", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n == 1'b1 && !busy, "R10", "idle after reset", int'(cs_n), 1);

        // R1 R5: single-block write, two address bytes
        snap();
        do_write(5, 3, 8'hA1, 1'b1, 1'b0);
        chk(got_done && !err_range && !err_timeout, "R1", "write done clean", int'(got_done), 1);
        chk(n_wren - e0 == 1, "R1", "write-enable frames", n_wren - e0, 1);
        chk(n_write - w0 == 1, "R1", "write frames", n_write - w0, 1);
        chk(n_wel_viol == 0, "R1", "write without latch", n_wel_viol, 0);
        chk(n_rdsr - s0 == BUSY_POLLS + 1, "R5", "status polls", n_rdsr - s0, BUSY_POLLS + 1);
        chk(wdq.size() == 0, "R11", "write bytes consumed", wdq.size(), 0);

        // R2 R7: two-byte read back
        snap();
        do_read(4, 5, 1'b1, 1'b0, "R2");
        chk(n_read - r0 == 1 && n_frames - f0 == 1, "R7", "read frame count", n_frames - f0, 1);

        // R4: write across two block edges
        snap();
        do_write(14, 20, 8'h11, 1'b1, 1'b0);
        chk(n_write - w0 == 3, "R4", "split write frames", n_write - w0, 3);
        chk(n_wren - e0 == 3, "R1", "one enable per piece", n_wren - e0, 3);
        chk(n_blk_viol == 0, "R4", "block crossings", n_blk_viol, 0);
        chk(n_rdsr - s0 == 3 * (BUSY_POLLS + 1), "R5", "polls per piece", n_rdsr - s0, 3 * (BUSY_POLLS + 1));
        do_read(14, 20, 1'b1, 1'b0, "R7");

        // R3: folded address bit
        do_write(9'h1F8, 4, 8'h77, 1'b1, 1'b1);
        chk(n_bad_op == 0, "R3", "unknown opcodes", n_bad_op, 0);
        do_read(9'h1F8, 8, 1'b1, 1'b1, "R3");
        chk(!err_range, "R8", "request ending at device size", int'(err_range), 0);
        do_read(9'h0FC, 8, 1'b0, 1'b1, "R3");

        // R2: one address byte
        do_write(8'h20, 2, 8'h3C, 1'b0, 1'b0);
        do_read(8'h1E, 6, 1'b0, 1'b0, "R2");
        chk(n_bad_op == 0, "R2", "unknown opcodes", n_bad_op, 0);

        // R8: out of range and zero length
        snap();
        run_op(1'b1, 9'h1FC, 5, 1'b1, 1'b0);
        chk(got_done && err_range, "R8", "range error", int'(err_range), 1);
        chk(n_frames == f0, "R8", "frames on reject", n_frames - f0, 0);
        run_op(1'b0, 10, 0, 1'b1, 1'b0);
        chk(got_done && !err_range, "R8", "zero length done", int'(err_range), 0);
        chk(n_frames == f0, "R8", "frames on zero length", n_frames - f0, 0);

        // R6: device stuck busy
        stuck = 1'b1;
        snap();
        do_write(8'h40, 1, 8'h99, 1'b1, 1'b0);
        chk(got_done && err_timeout, "R6", "timeout flag", int'(err_timeout), 1);
        chk(n_rdsr - s0 == POLL_LIMIT, "R6", "polls before timeout", n_rdsr - s0, POLL_LIMIT);
        repeat (50) @(negedge clk);
        chk(n_frames - f0 == 2 + POLL_LIMIT, "R6", "frames after abort", n_frames - f0, 2 + POLL_LIMIT);
        stuck = 1'b0;
        do_read(8'h40, 1, 1'b1, 1'b0, "R6");
        chk(!err_timeout, "R6", "timeout cleared by start", int'(err_timeout), 0);

        chk(half_viol == 0, "R9", "sck high-phase length", half_viol, 0);
        chk(sck_no_cs == 0, "R9", "sck high without cs", sck_no_cs, 0);
        chk(wready_rd == 0, "R11", "wr_ready during read", wready_rd, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule